// File: doc/BRIEF.md
# ULPI PHY Register Bank

This block holds the byte-wide control and status registers that a PHY exposes to its link partner over a ULPI-style request port. The link side presents an address, a data byte and a write or read strobe each clock. Every control register answers at three consecutive addresses. The first replaces the contents. The second sets the bits that are 1 in the data. The third clears the bits that are 1 in the data. Reads return the addressed register combinationally, in the same cycle as the request.

Besides the control bytes, the bank holds two interrupt enable masks, one for rising and one for falling edges. It also shows the live monitored status signals and a byte of debug signals. A latch register collects enabled edges of the status signals until the link reads it. Selected control bits are also brought out as named pins for the rest of the PHY.

Top module: `phy_regbank`

## Requirements
- R1: After reset, function control reads 41h, interface control 00h, OTG control 06h, rising-edge enable 1Fh, falling-edge enable 1Fh, power control 00h and the event latch 00h.
- R2: A write to a control register's base address replaces its contents. The base addresses are function 04h, interface 07h, OTG 0Ah, rising enable 0Dh, falling enable 10h and power 3Dh.
- R3: A write to base+1 ORs the data into the register.
- R4: A write to base+2 clears every register bit whose data bit is 1.
- R5: A read at base, base+1 or base+2 returns the register's current value on rd_data in the same cycle.
- R6: suspend_n_o follows function control bit 6, prot_off_o follows interface control bit 7 and ind_pass_o follows interface control bit 6. func_o, intf_o, otg_o and pwr_o carry the whole bytes.
- R7: Addresses 00h to 03h read the identity constants in this order: vendor low, vendor high, product low, product high. Writes to them have no effect.
- R8: Address 13h reads mon_status in its low bits with zeros above. Address 15h reads dbg_in. Writes to either address have no effect.
- R9: Each clock, status bit i of the event latch (address 14h) is set when mon_status[i] differs from its value at the previous clock edge. A 0-to-1 change sets the bit if rising-enable bit i is 1. A 1-to-0 change sets it if falling-enable bit i is 1. The sampled history is 0 at reset.
- R10: A read strobe at 14h clears the latch at the next edge, except for bits that have an enabled event in the same cycle, which stay set.
- R11: Every other address reads 00h, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_addr | input | 6 | Register address |
| req_wdata | input | 8 | Write data |
| req_wr | input | 1 | Write strobe |
| req_rd | input | 1 | Read strobe (clears the latch at 14h) |
| mon_status | input | STAT_W | Live monitored status signals |
| dbg_in | input | 8 | Debug signals shown at 15h |
| rd_data | output | 8 | Read data for req_addr |
| func_o | output | 8 | Function control byte |
| intf_o | output | 8 | Interface control byte |
| otg_o | output | 8 | OTG control byte |
| pwr_o | output | 8 | Power control byte |
| suspend_n_o | output | 1 | Active-low suspend |
| prot_off_o | output | 1 | Interface protection disabled |
| ind_pass_o | output | 1 | Indicator pass-through |

## Verification
The properties assume that req_addr and req_wdata are defined on every edge where a strobe is high. They also assume that mon_status is sampled cleanly, with no change inside a cycle. The stimulus drives every input on the falling edge and holds mon_status at zero during reset. As a result, the edge history of the latch starts from a known zero. Random traffic draws addresses over the whole 6-bit space, so it reaches aliases, unmapped holes and latch reads while status bits toggle.

// File: rtl/phy_regbank_pkg.sv
package phy_regbank_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int NCTL   = 6;

  localparam int CI_FUNC = 0;
  localparam int CI_INTF = 1;
  localparam int CI_OTG  = 2;
  localparam int CI_IENR = 3;
  localparam int CI_IENF = 4;
  localparam int CI_PWR  = 5;

  localparam logic [ADDR_W-1:0] A_STAT  = 6'h13;
  localparam logic [ADDR_W-1:0] A_LATCH = 6'h14;
  localparam logic [ADDR_W-1:0] A_DBG   = 6'h15;

  typedef enum logic [1:0] {OP_WR = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_NONE = 2'd3} op_e;

  function automatic logic [ADDR_W-1:0] ctl_base(input int idx);
    case (idx)
      CI_FUNC: ctl_base = 6'h04;
      CI_INTF: ctl_base = 6'h07;
      CI_OTG:  ctl_base = 6'h0A;
      CI_IENR: ctl_base = 6'h0D;
      CI_IENF: ctl_base = 6'h10;
      default: ctl_base = 6'h3D;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ctl_reset(input int idx);
    case (idx)
      CI_FUNC: ctl_reset = 8'h41;
      CI_OTG:  ctl_reset = 8'h06;
      CI_IENR: ctl_reset = 8'h1F;
      CI_IENF: ctl_reset = 8'h1F;
      default: ctl_reset = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/phy_regbank_dec.sv
module phy_regbank_dec
  import phy_regbank_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [NCTL-1:0]   ctl_hit,
  output op_e               op,
  output logic              hit_id,
  output logic              hit_stat,
  output logic              hit_latch,
  output logic              hit_dbg
);
  logic [ADDR_W-1:0] diff [NCTL];
  logic [1:0]        ofs  [NCTL];

  for (genvar g = 0; g < NCTL; g++) begin : g_win
    assign diff[g]    = addr - ctl_base(g);
    assign ctl_hit[g] = (diff[g] < 6'd3);
    assign ofs[g]     = diff[g][1:0];
  end

  always_comb begin
    op = OP_NONE;
    for (int i = 0; i < NCTL; i++) begin
      if (ctl_hit[i]) op = op_e'(ofs[i]);
    end
  end

  assign hit_id    = (addr < 6'h04);
  assign hit_stat  = (addr == A_STAT);
  assign hit_latch = (addr == A_LATCH);
  assign hit_dbg   = (addr == A_DBG);
endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
  import phy_regbank_pkg::*;
#(
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  op_e               op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) begin
      case (op)
        OP_WR:   q_nxt = wdata;
        OP_SET:  q_nxt = q | wdata;
        OP_CLR:  q_nxt = q & ~wdata;
        default: q_nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (we) q <= q_nxt;
  end
endmodule

// File: rtl/phy_irq_latch.sv
module phy_irq_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] en_rise,
  input  logic [W-1:0] en_fall,
  input  logic         rd_clr,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] hist_q;
  logic [W-1:0] evt;
  logic [W-1:0] latch_nxt;

  always_comb begin
    evt       = (status & ~hist_q & en_rise) | (~status & hist_q & en_fall);
    latch_nxt = rd_clr ? evt : (latch_q | evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q  <= '0;
      latch_q <= '0;
    end else begin
      hist_q  <= status;
      latch_q <= latch_nxt;
    end
  end
endmodule

// File: rtl/phy_regbank.sv
module phy_regbank
  import phy_regbank_pkg::*;
#(
  parameter int          STAT_W     = 5,
  parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0] PRODUCT_ID = 16'h3C4D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [STAT_W-1:0] mon_status,
  input  logic [DATA_W-1:0] dbg_in,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] func_o,
  output logic [DATA_W-1:0] intf_o,
  output logic [DATA_W-1:0] otg_o,
  output logic [DATA_W-1:0] pwr_o,
  output logic              suspend_n_o,
  output logic              prot_off_o,
  output logic              ind_pass_o
);
  localparam int BIT_SUSP = 6;
  localparam int BIT_PROT = 7;
  localparam int BIT_PASS = 6;

  logic [NCTL-1:0]   ctl_hit;
  op_e               op;
  logic              hit_id, hit_stat, hit_latch, hit_dbg;
  logic [DATA_W-1:0] ctl_q [NCTL];
  logic [STAT_W-1:0] latch_q;
  logic              latch_clr;

  phy_regbank_dec u_dec (
    .addr      (req_addr),
    .ctl_hit   (ctl_hit),
    .op        (op),
    .hit_id    (hit_id),
    .hit_stat  (hit_stat),
    .hit_latch (hit_latch),
    .hit_dbg   (hit_dbg)
  );

  for (genvar g = 0; g < NCTL; g++) begin : g_ctl
    phy_ctl_reg #(.RST_VAL(ctl_reset(g))) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (req_wr & ctl_hit[g]),
      .op    (op),
      .wdata (req_wdata),
      .q     (ctl_q[g])
    );
  end

  assign latch_clr = req_rd & hit_latch;

  phy_irq_latch #(.W(STAT_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .status  (mon_status),
    .en_rise (ctl_q[CI_IENR][STAT_W-1:0]),
    .en_fall (ctl_q[CI_IENF][STAT_W-1:0]),
    .rd_clr  (latch_clr),
    .latch_q (latch_q)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NCTL; i++) begin
      if (ctl_hit[i]) rd_data = ctl_q[i];
    end
    if (hit_id) begin
      case (req_addr[1:0])
        2'd0:    rd_data = VENDOR_ID[7:0];
        2'd1:    rd_data = VENDOR_ID[15:8];
        2'd2:    rd_data = PRODUCT_ID[7:0];
        default: rd_data = PRODUCT_ID[15:8];
      endcase
    end
    if (hit_stat)  rd_data = DATA_W'(mon_status);
    if (hit_latch) rd_data = DATA_W'(latch_q);
    if (hit_dbg)   rd_data = dbg_in;
  end

  assign func_o      = ctl_q[CI_FUNC];
  assign intf_o      = ctl_q[CI_INTF];
  assign otg_o       = ctl_q[CI_OTG];
  assign pwr_o       = ctl_q[CI_PWR];
  assign suspend_n_o = ctl_q[CI_FUNC][BIT_SUSP];
  assign prot_off_o  = ctl_q[CI_INTF][BIT_PROT];
  assign ind_pass_o  = ctl_q[CI_INTF][BIT_PASS];
endmodule

// File: rtl/phy_regbank_chk.sv
module phy_regbank_chk #(
  parameter int STAT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        req_addr,
  input logic [7:0]        req_wdata,
  input logic              req_wr,
  input logic              req_rd,
  input logic [STAT_W-1:0] mon_status,
  input logic [7:0]        rd_data,
  input logic [7:0]        func_o,
  input logic [7:0]        intf_o,
  input logic [7:0]        otg_o,
  input logic [7:0]        pwr_o,
  input logic [STAT_W-1:0] latch_q
);
  logic mapped;
  assign mapped = (req_addr <= 6'h15) || (req_addr >= 6'h3D);

  p_set_or_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == 6'h05) |=> ((func_o & $past(req_wdata)) == $past(req_wdata)));

  p_clear_and_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr == 6'h09) |=> ((intf_o & $past(req_wdata)) == 8'h00));

  p_hole_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !mapped) |=> ($stable(func_o) && $stable(intf_o) && $stable(otg_o) && $stable(pwr_o)));

  p_hole_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (rd_data == 8'h00));

  p_status_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr == 6'h13) |-> (rd_data[STAT_W-1:0] == mon_status));

  p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && req_addr == 6'h14) |=> ((latch_q & $past(latch_q)) == $past(latch_q)));
endmodule

bind phy_regbank phy_regbank_chk #(.STAT_W(STAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .req_wr     (req_wr),
  .req_rd     (req_rd),
  .mon_status (mon_status),
  .rd_data    (rd_data),
  .func_o     (func_o),
  .intf_o     (intf_o),
  .otg_o      (otg_o),
  .pwr_o      (pwr_o),
  .latch_q    (latch_q)
);

// File: tb/phy_regbank_bench.sv
module phy_regbank_bench;
  localparam int SW = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_wr = 1'b0;
  logic       req_rd = 1'b0;
  logic [SW-1:0] mon_status = '0;
  logic [7:0] dbg_in = '0;
  logic [7:0] rd_data, func_o, intf_o, otg_o, pwr_o;
  logic       suspend_n_o, prot_off_o, ind_pass_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [7:0]    m_ctl [6];
  logic [SW-1:0] m_latch;
  logic [SW-1:0] m_prev;
  int            m_base [6] = '{'h04, 'h07, 'h0A, 'h0D, 'h10, 'h3D};
  logic [7:0]    m_rst  [6] = '{8'h41, 8'h00, 8'h06, 8'h1F, 8'h1F, 8'h00};

  always #2.5 clk = ~clk;

  phy_regbank u_phy_regbank (
    .clk(clk), .rst_n(rst_n), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_wr(req_wr), .req_rd(req_rd), .mon_status(mon_status), .dbg_in(dbg_in),
    .rd_data(rd_data), .func_o(func_o), .intf_o(intf_o), .otg_o(otg_o),
    .pwr_o(pwr_o), .suspend_n_o(suspend_n_o), .prot_off_o(prot_off_o),
    .ind_pass_o(ind_pass_o)
  );

  function automatic int ctl_idx(input int a);
    for (int i = 0; i < 6; i++) if (a >= m_base[i] && a <= m_base[i] + 2) return i;
    return -1;
  endfunction

  function automatic logic [7:0] m_read(input int a);
    int k;
    k = ctl_idx(a);
    if (k >= 0) return m_ctl[k];
    case (a)
      0: return 8'h2B;
      1: return 8'h1A;
      2: return 8'h4D;
      3: return 8'h3C;
      'h13: return {3'b000, mon_status};
      'h14: return {3'b000, m_latch};
      'h15: return dbg_in;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    if (ctl_idx(a) >= 0) return "R5";
    if (a < 4) return "R7";
    if (a == 'h13 || a == 'h15) return "R8";
    if (a == 'h14) return "R9";
    return "R11";
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input int a, input logic [7:0] wd, input logic wr,
                      input logic rd, input logic [SW-1:0] mon, input logic [7:0] dbg);
    logic [SW-1:0] ev;
    int k;
    @(negedge clk);
    req_addr = 6'(a); req_wdata = wd; req_wr = wr; req_rd = rd;
    mon_status = mon; dbg_in = dbg;
    #1;
    check(tag, "rd_data", rd_data, m_read(a));
    check("R6", "func_o", func_o, m_ctl[0]);
    check("R6", "intf_o", intf_o, m_ctl[1]);
    check("R6", "otg_o", otg_o, m_ctl[2]);
    check("R6", "pwr_o", pwr_o, m_ctl[5]);
    check("R6", "pins", {5'b0, suspend_n_o, prot_off_o, ind_pass_o},
          {5'b0, m_ctl[0][6], m_ctl[1][7], m_ctl[1][6]});
    @(posedge clk);
    ev = (mon & ~m_prev & m_ctl[3][SW-1:0]) | (~mon & m_prev & m_ctl[4][SW-1:0]);
    m_latch = (rd && a == 'h14) ? ev : (m_latch | ev);
    m_prev = mon;
    k = ctl_idx(a);
    if (wr && k >= 0) begin
      case (a - m_base[k])
        0: m_ctl[k] = wd;
        1: m_ctl[k] = m_ctl[k] | wd;
        default: m_ctl[k] = m_ctl[k] & ~wd;
      endcase
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] mon;
    for (int i = 0; i < 6; i++) m_ctl[i] = m_rst[i];
    m_latch = '0; m_prev = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values at every control base and the latch
    step("R1", 'h04, 0, 0, 0, 0, 0);
    step("R1", 'h07, 0, 0, 0, 0, 0);
    step("R1", 'h0A, 0, 0, 0, 0, 0);
    step("R1", 'h0D, 0, 0, 0, 0, 0);
    step("R1", 'h10, 0, 0, 0, 0, 0);
    step("R1", 'h3D, 0, 0, 0, 0, 0);
    step("R1", 'h14, 0, 0, 0, 0, 0);
    // R2 plain writes
    step("R2", 'h04, 8'h5A, 1, 0, 0, 0);
    step("R2", 'h04, 0, 0, 1, 0, 0);
    step("R2", 'h0A, 8'hF0, 1, 0, 0, 0);
    step("R2", 'h3D, 8'h33, 1, 0, 0, 0);
    step("R2", 'h3D, 0, 0, 1, 0, 0);
    // R3 set, R5 read through other aliases
    step("R3", 'h05, 8'h81, 1, 0, 0, 0);
    step("R5", 'h06, 0, 0, 1, 0, 0);
    step("R3", 'h0B, 8'h0F, 1, 0, 0, 0);
    step("R5", 'h0C, 0, 0, 1, 0, 0);
    // R4 clear, R6 pins
    step("R4", 'h06, 8'h40, 1, 0, 0, 0);
    step("R6", 'h04, 0, 0, 1, 0, 0);
    step("R6", 'h07, 8'hC0, 1, 0, 0, 0);
    step("R4", 'h09, 8'h80, 1, 0, 0, 0);
    step("R6", 'h08, 0, 0, 1, 0, 0);
    step("R4", 'h3F, 8'hFF, 1, 0, 0, 0);
    // R7 identity bytes, writes ignored
    for (int a = 0; a < 4; a++) step("R7", a, 8'hFF, 1, 1, 0, 0);
    for (int a = 0; a < 4; a++) step("R7", a, 0, 0, 1, 0, 0);
    // R8 status and debug
    step("R8", 'h13, 8'hFF, 1, 1, 5'h15, 8'hA5);
    step("R8", 'h15, 8'h00, 1, 1, 5'h15, 8'h3C);
    // R9 edge events with split enables
    step("R9", 'h14, 0, 0, 1, 5'h15, 0);
    step("R9", 'h0D, 8'h01, 1, 0, 5'h15, 0);
    step("R9", 'h10, 8'h02, 1, 0, 5'h15, 0);
    step("R9", 'h14, 0, 0, 1, 5'h00, 0);
    step("R9", 'h14, 0, 0, 0, 5'h03, 0);
    step("R9", 'h14, 0, 0, 0, 5'h01, 0);
    step("R9", 'h14, 0, 0, 0, 5'h01, 0);
    // R10 read clears, event in the read cycle wins
    step("R10", 'h14, 0, 0, 1, 5'h00, 0);
    step("R10", 'h14, 0, 0, 1, 5'h01, 0);
    step("R10", 'h14, 0, 0, 1, 5'h01, 0);
    step("R10", 'h14, 0, 0, 0, 5'h01, 0);
    // R11 holes
    step("R11", 'h20, 8'hFF, 1, 1, 5'h01, 0);
    step("R11", 'h3C, 8'hFF, 1, 1, 5'h01, 0);
    step("R11", 'h16, 8'hFF, 1, 1, 5'h01, 0);
    // mixed traffic
    mon = 5'h01;
    for (int n = 0; n < 400; n++) begin
      int a;
      a = $urandom_range(0, 63);
      if (n % 3 == 0) mon = mon ^ SW'($urandom_range(0, 31));
      step(tag_of(a), a, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)), mon, 8'($urandom_range(0, 255)));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule